// File: doc/BRIEF.md
# Bottleneck Wait-Cycle Tally Table

This block keeps a small fully associative table, shared by every core, that measures how much thread waiting each software bottleneck causes. A core that starts waiting on a bottleneck sends its identifier on the arrival channel. When the wait ends, the core sends the same identifier on the leave channel. Each table entry holds an identifier, the number of threads waiting on it right now, and a running total of waiting cycles. On every clock edge, each live entry adds its current waiter count to its total. One waiter adds 1 per cycle, three waiters add 3, and an entry with no waiters keeps its total unchanged.

A scheduler reads the total for an identifier through a lookup channel, and the answer arrives one cycle later. An identifier that is not in the table is allocated on its first arrival, using a free slot if one exists. When the table is full, the new identifier takes the slot of the entry with the smallest total. Each time an entry's total rises above the programmable limit, that entry's identifier is queued for acceleration and sent out on a report stream.

The arrival, leave and lookup channels use valid/ready and never apply back-pressure: their ready outputs stay high, and a beat is taken on every cycle in which valid is high. The lookup response has no ready, because it always appears exactly one cycle after the request. The report stream does honour back-pressure. While `hot_valid` is high and `hot_ready` is low, the reported identifier stays on `hot_id` without change.

Top module: `wait_tally_table`

## Requirements
- R1: An arrival whose identifier is already in the table raises that entry's waiter count by one, and the count saturates at its maximum.
- R2: On every clock edge, each live entry's total grows by the waiter count it held before that edge, so zero waiters leave the total unchanged.
- R3: A leave lowers the matching entry's waiter count by one and stops at zero. The total is kept when the count reaches zero. A leave for an identifier that is not in the table has no effect and does not create an entry.
- R4: An arrival whose identifier is not in the table creates an entry with one waiter and a total of zero, placed in a free slot when one exists.
- R5: When the table is full, an arrival with a new identifier replaces the live entry with the smallest total (the lowest slot wins a tie). The replaced identifier then misses on lookup, even if it was the most recently used entry.
- R6: A leave is matched against the table as it stood before the cycle. An arrival and a leave for the same present identifier in the same cycle leave its count unchanged. An arrival that allocates an identifier in the same cycle as a leave for that identifier yields one waiter.
- R7: A total saturates at 2^TWC_W-1 and never wraps.
- R8: A lookup presented in one cycle produces `rsp_valid` in the next cycle, carrying the hit flag, the total as it stood when the lookup was presented, and `rsp_hot` = (total > `limit`). A miss returns hit 0, total 0 and hot 0. With no lookup, `rsp_valid` is 0.
- R9: When an entry's total goes from not above `limit` to above it, the entry's identifier is reported exactly once on the hot stream, and it stays stable while `hot_ready` is low. Lowering `limit` below a total that was under the old limit counts as a new crossing.
- R10: After reset the table is empty, and `rsp_valid` and `hot_valid` are 0.
- R11: `arr_ready`, `lv_ready` and `qry_ready` are always high, so these channels never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| limit | input | TWC_W | Acceleration threshold on the total |
| arr_valid | input | 1 | Wait-start event valid |
| arr_ready | output | 1 | Always high |
| arr_id | input | ID_W | Bottleneck identifier of the wait start |
| lv_valid | input | 1 | Wait-end event valid |
| lv_ready | output | 1 | Always high |
| lv_id | input | ID_W | Bottleneck identifier of the wait end |
| qry_valid | input | 1 | Lookup request valid |
| qry_ready | output | 1 | Always high |
| qry_id | input | ID_W | Identifier to look up |
| rsp_valid | output | 1 | Lookup answer valid, one cycle after the request |
| rsp_hit | output | 1 | Identifier was present |
| rsp_total | output | TWC_W | Waiting-cycle total of the identifier |
| rsp_hot | output | 1 | Total is above `limit` |
| hot_valid | output | 1 | Acceleration report valid |
| hot_ready | input | 1 | Report consumer ready |
| hot_id | output | ID_W | Identifier to accelerate |

## Verification
A waiter count that is off by one never appears directly at the ports. It shows up as a wrong slope in the totals, visible to a lookup on the next edge, so the bench reads totals at back-to-back lookups and after known wait intervals. A wrong choice of victim shows up at the first lookup of the identifier that should have survived, which misses when it should hit. A stray or lost crossing appears on the hot stream two edges after the total passes the limit, so the bench watches the stream both before and after that point, and while it is stalled.

// File: rtl/wtt_pkg.sv
package wtt_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wtt_entry.sv
module wtt_entry
  import wtt_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int WAIT_W = 6,
  parameter int TWC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TWC_W-1:0]  limit,
  input  logic              load,
  input  logic [ID_W-1:0]   load_id,
  input  step_e             step,
  input  logic              take,
  output logic              live,
  output logic [ID_W-1:0]   tag,
  output logic [TWC_W-1:0]  total,
  output logic              flag
);
  localparam logic [WAIT_W-1:0] W_MAX = '1;
  localparam logic [TWC_W-1:0]  T_MAX = '1;

  logic [WAIT_W-1:0] waiters;
  logic              above_q;
  logic [TWC_W:0]    sum;
  logic [TWC_W-1:0]  total_nx;
  logic              above_nx;

  // saturating accumulate of the count held before this edge
  assign sum      = {1'b0, total} + (TWC_W+1)'(waiters);
  assign total_nx = sum[TWC_W] ? T_MAX : sum[TWC_W-1:0];
  assign above_nx = total_nx > limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= 1'b0;
      tag     <= '0;
      waiters <= '0;
      total   <= '0;
      above_q <= 1'b0;
      flag    <= 1'b0;
    end else if (load) begin
      live    <= 1'b1;
      tag     <= load_id;
      waiters <= WAIT_W'(1);
      total   <= '0;
      above_q <= 1'b0;
      flag    <= 1'b0;
    end else if (live) begin
      total   <= total_nx;
      above_q <= above_nx;
      flag    <= (flag & ~take) | (above_nx & ~above_q);
      unique case (step)
        STEP_UP:   if (waiters != W_MAX) waiters <= waiters + WAIT_W'(1);
        STEP_DOWN: if (waiters != '0)    waiters <= waiters - WAIT_W'(1);
        default:   waiters <= waiters;
      endcase
    end
  end
endmodule

// File: rtl/wtt_victim.sv
module wtt_victim
  import wtt_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int TWC_W   = 24,
  localparam int IDX_W  = idx_bits(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            live,
  input  logic [ENTRIES-1:0][TWC_W-1:0] totals,
  output logic [IDX_W-1:0]              victim
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] min_idx;
  logic [TWC_W-1:0] min_val;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    min_idx = '0;
    min_val = totals[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (totals[i] < min_val) begin
        min_val = totals[i];
        min_idx = IDX_W'(i);
      end
    end
    victim = free_found ? free_idx : min_idx;
  end
endmodule

// File: rtl/wtt_report.sv
module wtt_report
  import wtt_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ID_W    = 16,
  localparam int IDX_W  = idx_bits(ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ENTRIES-1:0]           flags,
  input  logic [ENTRIES-1:0][ID_W-1:0] tags,
  input  logic                         hot_ready,
  output logic                         hot_valid,
  output logic [ID_W-1:0]              hot_id,
  output logic [ENTRIES-1:0]           take
);
  logic             any;
  logic [IDX_W-1:0] sel;
  logic             load;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (flags[i]) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign load = any && (!hot_valid || hot_ready);

  always_comb begin
    take = '0;
    if (load) take[sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_valid <= 1'b0;
      hot_id    <= '0;
    end else if (load) begin
      hot_valid <= 1'b1;
      hot_id    <= tags[sel];
    end else if (hot_ready) begin
      hot_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wait_tally_table.sv
module wait_tally_table
  import wtt_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ID_W    = 16,
  parameter int WAIT_W  = 6,
  parameter int TWC_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TWC_W-1:0] limit,
  input  logic             arr_valid,
  output logic             arr_ready,
  input  logic [ID_W-1:0]  arr_id,
  input  logic             lv_valid,
  output logic             lv_ready,
  input  logic [ID_W-1:0]  lv_id,
  input  logic             qry_valid,
  output logic             qry_ready,
  input  logic [ID_W-1:0]  qry_id,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [TWC_W-1:0] rsp_total,
  output logic             rsp_hot,
  output logic             hot_valid,
  input  logic             hot_ready,
  output logic [ID_W-1:0]  hot_id
);
  localparam int IDX_W = idx_bits(ENTRIES);

  logic [ENTRIES-1:0]            live;
  logic [ENTRIES-1:0][ID_W-1:0]  tags;
  logic [ENTRIES-1:0][TWC_W-1:0] totals;
  logic [ENTRIES-1:0]            flags;
  logic [ENTRIES-1:0]            take;
  logic [ENTRIES-1:0]            arr_hit;
  logic [ENTRIES-1:0]            lv_hit;
  logic [ENTRIES-1:0]            qry_hit;
  logic [IDX_W-1:0]              victim;
  logic                          alloc;
  logic [TWC_W-1:0]              sel_total;

  assign arr_ready = 1'b1;
  assign lv_ready  = 1'b1;
  assign qry_ready = 1'b1;

  assign alloc = arr_valid && (arr_hit == '0);

  wtt_victim #(.ENTRIES(ENTRIES), .TWC_W(TWC_W)) victim_i (
    .live   (live),
    .totals (totals),
    .victim (victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic  up, dn, load;
    step_e step;

    assign arr_hit[g] = live[g] && (tags[g] == arr_id);
    assign lv_hit[g]  = live[g] && (tags[g] == lv_id);
    assign qry_hit[g] = live[g] && (tags[g] == qry_id);

    assign up   = arr_valid && arr_hit[g];
    assign dn   = lv_valid && lv_hit[g];
    assign load = alloc && (victim == IDX_W'(g));
    assign step = (up && !dn) ? STEP_UP : ((dn && !up) ? STEP_DOWN : STEP_HOLD);

    wtt_entry #(.ID_W(ID_W), .WAIT_W(WAIT_W), .TWC_W(TWC_W)) entry_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .limit   (limit),
      .load    (load),
      .load_id (arr_id),
      .step    (step),
      .take    (take[g]),
      .live    (live[g]),
      .tag     (tags[g]),
      .total   (totals[g]),
      .flag    (flags[g])
    );
  end

  always_comb begin
    sel_total = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (qry_hit[i]) sel_total = sel_total | totals[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_total <= '0;
      rsp_hot   <= 1'b0;
    end else begin
      rsp_valid <= qry_valid;
      rsp_hit   <= qry_valid && (qry_hit != '0);
      rsp_total <= qry_valid ? sel_total : '0;
      rsp_hot   <= qry_valid && (qry_hit != '0) && (sel_total > limit);
    end
  end

  wtt_report #(.ENTRIES(ENTRIES), .ID_W(ID_W)) report_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .tags      (tags),
    .hot_ready (hot_ready),
    .hot_valid (hot_valid),
    .hot_id    (hot_id),
    .take      (take)
  );
endmodule

// File: rtl/wait_tally_table_chk.sv
module wait_tally_table_chk #(
  parameter int ID_W  = 16,
  parameter int TWC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TWC_W-1:0] limit,
  input logic             qry_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [TWC_W-1:0] rsp_total,
  input logic             rsp_hot,
  input logic             hot_valid,
  input logic             hot_ready,
  input logic [ID_W-1:0]  hot_id
);
  a_r8_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> rsp_valid);

  a_r8_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> !rsp_valid);

  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_total == '0 && !rsp_hot));

  a_r8_hot_above: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hot |-> (rsp_hit && rsp_total > $past(limit)));

  a_r9_hot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_valid && !hot_ready) |=> (hot_valid && $stable(hot_id)));
endmodule

bind wait_tally_table wait_tally_table_chk #(.ID_W(ID_W), .TWC_W(TWC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .limit     (limit),
  .qry_valid (qry_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_total (rsp_total),
  .rsp_hot   (rsp_hot),
  .hot_valid (hot_valid),
  .hot_ready (hot_ready),
  .hot_id    (hot_id)
);

// File: tb/wait_tally_table_tb_top.sv
module wait_tally_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int ID_W    = 8;
  localparam int WAIT_W  = 4;
  localparam int TWC_W   = 12;

  logic             clk;
  logic             rst_n;
  logic [TWC_W-1:0] limit;
  logic             arr_valid, arr_ready;
  logic [ID_W-1:0]  arr_id;
  logic             lv_valid, lv_ready;
  logic [ID_W-1:0]  lv_id;
  logic             qry_valid, qry_ready;
  logic [ID_W-1:0]  qry_id;
  logic             rsp_valid, rsp_hit, rsp_hot;
  logic [TWC_W-1:0] rsp_total;
  logic             hot_valid, hot_ready;
  logic [ID_W-1:0]  hot_id;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  wait_tally_table #(.ENTRIES(ENTRIES), .ID_W(ID_W), .WAIT_W(WAIT_W), .TWC_W(TWC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .limit(limit),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_id(arr_id),
    .lv_valid(lv_valid), .lv_ready(lv_ready), .lv_id(lv_id),
    .qry_valid(qry_valid), .qry_ready(qry_ready), .qry_id(qry_id),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_total(rsp_total), .rsp_hot(rsp_hot),
    .hot_valid(hot_valid), .hot_ready(hot_ready), .hot_id(hot_id)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; arr_valid = 0; lv_valid = 0; qry_valid = 0; hot_ready = 0;
    arr_id = '0; lv_id = '0; qry_id = '0; limit = '1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic arrive(input logic [ID_W-1:0] id);
    arr_valid = 1; arr_id = id; tick(1); arr_valid = 0;
  endtask

  task automatic leave(input logic [ID_W-1:0] id);
    lv_valid = 1; lv_id = id; tick(1); lv_valid = 0;
  endtask

  task automatic both(input logic [ID_W-1:0] id);
    arr_valid = 1; arr_id = id; lv_valid = 1; lv_id = id;
    tick(1);
    arr_valid = 0; lv_valid = 0;
  endtask

  task automatic ask(input logic [ID_W-1:0] id, input bit hit, input int total,
                     input bit hot, input string req);
    qry_valid = 1; qry_id = id; tick(1); qry_valid = 0;
    check(rsp_valid == 1'b1, {req, " rsp_valid"}, int'(rsp_valid), 1);
    check(rsp_hit == hit, {req, " hit"}, int'(rsp_hit), int'(hit));
    check(int'(rsp_total) == total, {req, " total"}, int'(rsp_total), total);
    check(rsp_hot == hot, {req, " hot"}, int'(rsp_hot), int'(hot));
  endtask

  task automatic t_reset();
    do_reset();
    check(rsp_valid == 0, "R10 rsp_valid", int'(rsp_valid), 0);
    check(hot_valid == 0, "R10 hot_valid", int'(hot_valid), 0);
    check(arr_ready && lv_ready && qry_ready, "R11 readies", int'({arr_ready, lv_ready, qry_ready}), 7);
    ask(8'h11, 0, 0, 0, "R10 empty");
  endtask

  task automatic t_single();
    arrive(8'h11); tick(9); leave(8'h11);
    ask(8'h11, 1, 10, 0, "R4 R2 single waiter");
    tick(3);
    ask(8'h11, 1, 10, 0, "R3 total kept");
  endtask

  task automatic t_two();
    arrive(8'h22);
    ask(8'h22, 1, 0, 0, "R4 fresh total");
    ask(8'h22, 1, 1, 0, "R2 slope one");
    arrive(8'h22);
    ask(8'h22, 1, 3, 0, "R1 second waiter");
    ask(8'h22, 1, 5, 0, "R2 slope two");
    leave(8'h22); leave(8'h22);
    ask(8'h22, 1, 10, 0, "R3 two leaves");
  endtask

  task automatic t_leave();
    leave(8'h7E);
    ask(8'h7E, 0, 0, 0, "R3 absent leave");
    leave(8'h11);
    tick(2);
    ask(8'h11, 1, 10, 0, "R3 leave at zero");
    arrive(8'h11); tick(4); leave(8'h11);
    ask(8'h11, 1, 15, 0, "R3 no wrap below zero");
  endtask

  task automatic t_same();
    both(8'h11); tick(3);
    ask(8'h11, 1, 15, 0, "R6 net zero idle");
    arrive(8'h11); both(8'h11); tick(3); leave(8'h11);
    ask(8'h11, 1, 20, 0, "R6 net zero busy");
    both(8'h44); tick(2); leave(8'h44);
    ask(8'h44, 1, 3, 0, "R6 alloc with leave");
  endtask

  task automatic t_lookup();
    ask(8'h99, 0, 0, 0, "R8 miss");
    check(rsp_valid == 1, "R8 valid once", int'(rsp_valid), 1);
    tick(1);
    check(rsp_valid == 0, "R8 quiet", int'(rsp_valid), 0);
  endtask

  task automatic t_evict();
    do_reset();
    for (int i = 0; i < ENTRIES; i++) begin
      int d;
      d = (i == 5) ? 1 : 3 + i;
      arrive(ID_W'(8'h60 + i)); tick(d - 1); leave(ID_W'(8'h60 + i));
    end
    arrive(8'h70); leave(8'h70);
    ask(8'h65, 0, 0, 0, "R5 min evicted");
    ask(8'h70, 1, 1, 0, "R5 newcomer");
    ask(8'h60, 1, 3, 0, "R5 survivor");
    arrive(8'h71); leave(8'h71);
    ask(8'h70, 0, 0, 0, "R5 recent but min evicted");
    ask(8'h71, 1, 1, 0, "R5 second newcomer");
    ask(8'h61, 1, 4, 0, "R5 survivor two");
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 8; i++) arrive(8'hA0);
    tick(600);
    ask(8'hA0, 1, 4095, 0, "R7 saturated");
    tick(5);
    ask(8'hA0, 1, 4095, 0, "R7 stays saturated");
    for (int i = 0; i < 8; i++) leave(8'hA0);
  endtask

  task automatic t_hot();
    do_reset();
    limit = 12'd5;
    arrive(8'hB0);
    tick(3);
    check(hot_valid == 0, "R9 not yet", int'(hot_valid), 0);
    tick(6);
    check(hot_valid == 1, "R9 crossing", int'(hot_valid), 1);
    check(hot_id == 8'hB0, "R9 id", int'(hot_id), 'hB0);
    tick(3);
    check(hot_valid == 1 && hot_id == 8'hB0, "R9 held", int'(hot_id), 'hB0);
    hot_ready = 1; tick(1); hot_ready = 0;
    check(hot_valid == 0, "R9 taken", int'(hot_valid), 0);
    tick(5);
    check(hot_valid == 0, "R9 once", int'(hot_valid), 0);
    leave(8'hB0);
    ask(8'hB0, 1, 19, 1, "R8 R9 hot lookup");
    arrive(8'hB1); leave(8'hB1);
    ask(8'hB1, 1, 1, 0, "R8 cold lookup");
    limit = 12'd100; tick(2);
    check(hot_valid == 0, "R9 raised limit", int'(hot_valid), 0);
    limit = 12'd10; tick(3);
    check(hot_valid == 1 && hot_id == 8'hB0, "R9 lowered limit", int'(hot_id), 'hB0);
    hot_ready = 1; tick(1); hot_ready = 0;
    check(hot_valid == 0, "R9 second take", int'(hot_valid), 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_two();
    t_leave();
    t_same();
    t_lookup();
    t_evict();
    t_sat();
    t_hot();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule